// File: doc/BRIEF.md
# SD Host Interrupt Status Controller

This block collects the event flags of an SD/MMC host controller into byte-wide status registers and drives a single interrupt line toward the processor. Command, data and error engines elsewhere in the host deliver one-cycle event pulses. The block turns them into sticky flags. Software clears a flag by writing a one to its bit.

Two mask bytes choose which flags may reach the interrupt. A global enable gates the whole line. Card presence is taken from either a dedicated detect pin or the DAT3 line, with a selectable polarity. The level is synchronised, and the block produces change and insertion flags from it. A third byte reports the live busy state of the command and data-response paths and holds an automatic clock-freeze enable.

Top module: `sdirq_ctrl`

## Requirements
- R1: A pulse on `evt_i[n]` sets status byte 1 bit n (bit0 SDIO, bit1 command/response done, bit2 response timeout, bit3 auto-stop done, bit4 data timeout, bit5 response CRC error, bit6 read CRC error, bit7 write CRC error). The flag becomes visible on the clock edge that samples the pulse and stays set until it is cleared.
- R2: Status byte 0 holds sticky flags in bit4 (multi-block done from `mblk_done_i`), bit5 (block done from `blk_done_i`), bit6 (card-detect change) and bit7 (card insertion). Bit1 shows the synchronised `wp_i`, bit2 the synchronised `cd_dat3_i` and bit3 the synchronised `cd_pin_i`. Bit0 reads 0.
- R3: A write to address 0 (status byte 0) or address 1 (status byte 1) clears every flag whose data bit is 1 and leaves the other flags unchanged. Writing 0xFF clears the whole byte.
- R4: When an event and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R5: Address 3 stores mask byte 0 and address 4 stores mask byte 1. `irq_o` is a register. It is 1 one cycle after any status byte 0 flag in bits 4..7, or any status byte 1 flag in bits 1..7, is set together with its mask bit while the global enable is 1.
- R6: Status byte 1 bit0 and mask byte 0 bits 0..3 never drive `irq_o`, whatever the mask contents.
- R7: Address 5 is the control byte. Bit7 is the global interrupt enable, and while it is 0, `irq_o` is 0 on the next cycle. Bits 3..0 read 0.
- R8: Control bit5 selects the detect pin and control bit6 selects DAT3 as the card-detect source. The pin wins when both are set. With neither set, the selected level is 0. Inputs pass through two flops, and each change of the selected level sets status byte 0 bit6 on the third clock edge after the input changes.
- R9: Control bit4 = 1 means a high level indicates a card and 0 means a low level does. When the card-present state goes from absent to present, status byte 0 bit7 is set. This includes the case where a control write makes a card count as present.
- R10: Status byte 2 bit4 shows `cmd_busy_i` and bit5 shows `dat_busy_i`, both one cycle late. Bit7 is a read/write clock-freeze enable written at address 2. The other bits read 0.
- R11: After reset, all status, mask and control bytes and `irq_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address (0 stat0, 1 stat1, 2 stat2, 3 mask0, 4 mask1, 5 control) |
| wr_data_i | input | 8 | Write data |
| evt_i | input | 8 | Event pulses aligned with status byte 1 |
| blk_done_i | input | 1 | Block done pulse |
| mblk_done_i | input | 1 | Multi-block done pulse |
| wp_i | input | 1 | Write-protect level (asynchronous) |
| cd_dat3_i | input | 1 | DAT3 card-detect level (asynchronous) |
| cd_pin_i | input | 1 | Detect-pin level (asynchronous) |
| cmd_busy_i | input | 1 | Command/response path busy |
| dat_busy_i | input | 1 | Data-response path busy |
| stat0_o | output | 8 | Status byte 0 |
| stat1_o | output | 8 | Status byte 1 |
| stat2_o | output | 8 | Status byte 2 |
| mask0_o | output | 8 | Mask byte 0 |
| mask1_o | output | 8 | Mask byte 1 |
| ctrl_o | output | 8 | Control byte |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with its default parameters: an 8-bit register width and a two-stage synchroniser. With these values the three-edge latency from a card-detect input change to its change flag is fixed and known, so the bench can sample the flag exactly on that cycle. A width of eight makes every status and mask bit position visible. The vector table can therefore walk masks that include the non-interrupting positions, such as bit0 of byte 1 and the low nibble of byte 0.

// File: rtl/sdirq_pkg.sv
package sdirq_pkg;

    localparam int REG_W  = 8;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        ADR_STAT0 = 3'd0,
        ADR_STAT1 = 3'd1,
        ADR_STAT2 = 3'd2,
        ADR_MASK0 = 3'd3,
        ADR_MASK1 = 3'd4,
        ADR_CTRL  = 3'd5
    } reg_addr_e;

    // Positions of status bits that may raise the interrupt
    localparam logic [REG_W-1:0] IRQ_OK0 = 8'hF0;
    localparam logic [REG_W-1:0] IRQ_OK1 = 8'hFE;

    // Control byte, upper nibble, MSB first
    typedef struct packed {
        logic irq_en;     // bit7
        logic cd_dat3;    // bit6
        logic cd_pin;     // bit5
        logic cd_act_hi;  // bit4
    } ctrl_t;

    function automatic logic [REG_W-1:0] ctrl_to_byte(input ctrl_t c);
        return {c, 4'b0000};
    endfunction

    function automatic logic irq_reduce(input logic [REG_W-1:0] s0,
                                        input logic [REG_W-1:0] m0,
                                        input logic [REG_W-1:0] s1,
                                        input logic [REG_W-1:0] m1);
        return |((s0 & m0 & IRQ_OK0) | (s1 & m1 & IRQ_OK1));
    endfunction

endpackage

// File: rtl/sdirq_sync.sv
module sdirq_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= d_i;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= '0;
                else     chain[s] <= chain[s-1];
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/sdirq_flags.sv
module sdirq_flags #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] set_i,
    input  logic [WIDTH-1:0] clr_i,
    output logic [WIDTH-1:0] flag_o
);
    logic [WIDTH-1:0] flag_q;

    always_ff @(posedge clk) begin
        if (rst) flag_q <= '0;
        else     flag_q <= (flag_q & ~clr_i) | set_i;
    end

    assign flag_o = flag_q;

    // R4: a set always lands, even against a clear
    assert_set_wins_R4: assert property (@(posedge clk) disable iff (rst)
        (!rst && set_i != '0) |=> ((flag_q & $past(set_i)) == $past(set_i)));

    // R3: cleared bits without a set drop to zero
    assert_w1c_clears_R3: assert property (@(posedge clk) disable iff (rst)
        (!rst && clr_i != '0 && set_i == '0) |=> ((flag_q & $past(clr_i)) == '0));

    // R1: flags are sticky while untouched
    assert_sticky_R1: assert property (@(posedge clk) disable iff (rst)
        (!rst && clr_i == '0 && set_i == '0) |=> $stable(flag_q));
endmodule

// File: rtl/sdirq_cd.sv
module sdirq_cd
    import sdirq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  pin_lvl_i,
    input  logic  dat3_lvl_i,
    input  ctrl_t ctrl_i,
    output logic  chg_o,
    output logic  ins_o
);
    logic sel_lvl;
    logic present;
    logic lvl_q;
    logic present_q;

    always_comb begin
        if (ctrl_i.cd_pin)       sel_lvl = pin_lvl_i;
        else if (ctrl_i.cd_dat3) sel_lvl = dat3_lvl_i;
        else                     sel_lvl = 1'b0;
    end

    assign present = (ctrl_i.cd_pin | ctrl_i.cd_dat3) & (sel_lvl ~^ ctrl_i.cd_act_hi);

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q     <= 1'b0;
            present_q <= 1'b0;
        end else begin
            lvl_q     <= sel_lvl;
            present_q <= present;
        end
    end

    assign chg_o = sel_lvl ^ lvl_q;
    assign ins_o = present & ~present_q;

    // R9: an insertion pulse never lasts two cycles
    assert_ins_single_R9: assert property (@(posedge clk) disable iff (rst)
        ins_o |=> !ins_o);
endmodule

// File: rtl/sdirq_ctrl.sv
module sdirq_ctrl
    import sdirq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en_i,
    input  logic [ADDR_W-1:0]   wr_addr_i,
    input  logic [REG_W-1:0]    wr_data_i,
    input  logic [REG_W-1:0]    evt_i,
    input  logic                blk_done_i,
    input  logic                mblk_done_i,
    input  logic                wp_i,
    input  logic                cd_dat3_i,
    input  logic                cd_pin_i,
    input  logic                cmd_busy_i,
    input  logic                dat_busy_i,
    output logic [REG_W-1:0]    stat0_o,
    output logic [REG_W-1:0]    stat1_o,
    output logic [REG_W-1:0]    stat2_o,
    output logic [REG_W-1:0]    mask0_o,
    output logic [REG_W-1:0]    mask1_o,
    output logic [REG_W-1:0]    ctrl_o,
    output logic                irq_o
);
    localparam int HI_W = REG_W / 2;

    logic [REG_W-1:0] mask0_q, mask1_q;
    ctrl_t            ctrl_q;
    logic             clkfrz_q;
    logic [1:0]       busy_q;
    logic             irq_q;

    logic [2:0]       lvl_sync;   // {pin, dat3, wp}
    logic             cd_chg, cd_ins;

    logic [HI_W-1:0]  set0, clr0, flag0_q;
    logic [REG_W-1:0] clr1, flag1_q;
    logic [REG_W-1:0] stat0_full;

    logic wr_s0, wr_s1, wr_s2, wr_m0, wr_m1, wr_ct;

    always_comb begin
        wr_s0 = 1'b0; wr_s1 = 1'b0; wr_s2 = 1'b0;
        wr_m0 = 1'b0; wr_m1 = 1'b0; wr_ct = 1'b0;
        if (wr_en_i) begin
            case (reg_addr_e'(wr_addr_i))
                ADR_STAT0: wr_s0 = 1'b1;
                ADR_STAT1: wr_s1 = 1'b1;
                ADR_STAT2: wr_s2 = 1'b1;
                ADR_MASK0: wr_m0 = 1'b1;
                ADR_MASK1: wr_m1 = 1'b1;
                ADR_CTRL:  wr_ct = 1'b1;
                default:   ;
            endcase
        end
    end

    sdirq_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i ({cd_pin_i, cd_dat3_i, wp_i}),
        .q_o (lvl_sync)
    );

    sdirq_cd u_cd (
        .clk        (clk),
        .rst        (rst),
        .pin_lvl_i  (lvl_sync[2]),
        .dat3_lvl_i (lvl_sync[1]),
        .ctrl_i     (ctrl_q),
        .chg_o      (cd_chg),
        .ins_o      (cd_ins)
    );

    assign set0 = {cd_ins, cd_chg, blk_done_i, mblk_done_i};
    assign clr0 = wr_s0 ? wr_data_i[REG_W-1:HI_W] : '0;
    assign clr1 = wr_s1 ? wr_data_i : '0;

    sdirq_flags #(.WIDTH(HI_W)) u_flags0 (
        .clk    (clk),
        .rst    (rst),
        .set_i  (set0),
        .clr_i  (clr0),
        .flag_o (flag0_q)
    );

    sdirq_flags #(.WIDTH(REG_W)) u_flags1 (
        .clk    (clk),
        .rst    (rst),
        .set_i  (evt_i),
        .clr_i  (clr1),
        .flag_o (flag1_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mask0_q  <= '0;
            mask1_q  <= '0;
            ctrl_q   <= '0;
            clkfrz_q <= 1'b0;
            busy_q   <= '0;
        end else begin
            if (wr_m0) mask0_q  <= wr_data_i;
            if (wr_m1) mask1_q  <= wr_data_i;
            if (wr_ct) ctrl_q   <= ctrl_t'(wr_data_i[REG_W-1:HI_W]);
            if (wr_s2) clkfrz_q <= wr_data_i[7];
            busy_q <= {dat_busy_i, cmd_busy_i};
        end
    end

    assign stat0_full = {flag0_q, lvl_sync, 1'b0};

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= ctrl_q.irq_en & irq_reduce(stat0_full, mask0_q, flag1_q, mask1_q);
    end

    assign stat0_o = stat0_full;
    assign stat1_o = flag1_q;
    assign stat2_o = {clkfrz_q, 1'b0, busy_q, 4'b0000};
    assign mask0_o = mask0_q;
    assign mask1_o = mask1_q;
    assign ctrl_o  = ctrl_to_byte(ctrl_q);
    assign irq_o   = irq_q;

    // R7: global enable low forces the line low next cycle
    assert_gate_off_R7: assert property (@(posedge clk) disable iff (rst)
        (!rst && !ctrl_q.irq_en) |=> !irq_q);

    // R6: with no interrupting flag set, the line stays low
    assert_no_source_R6: assert property (@(posedge clk) disable iff (rst)
        (!rst && flag0_q == '0 && (flag1_q & IRQ_OK1) == '0) |=> !irq_q);

    // R5: a rising interrupt was enabled in the previous cycle
    assert_rise_enabled_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_q) |-> $past(ctrl_q.irq_en));

    // R8: a detected level change is recorded
    assert_cd_change_R8: assert property (@(posedge clk) disable iff (rst)
        (!rst && cd_chg) |=> flag0_q[2]);
endmodule

// File: tb/sdirq_ctrl_bench.sv
`timescale 1ns/1ps
module sdirq_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en_i = 1'b0;
    logic [2:0] wr_addr_i = '0;
    logic [7:0] wr_data_i = '0;
    logic [7:0] evt_i = '0;
    logic       blk_done_i = 1'b0, mblk_done_i = 1'b0;
    logic       wp_i = 1'b0, cd_dat3_i = 1'b0, cd_pin_i = 1'b0;
    logic       cmd_busy_i = 1'b0, dat_busy_i = 1'b0;
    logic [7:0] stat0_o, stat1_o, stat2_o, mask0_o, mask1_o, ctrl_o;
    logic       irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sdirq_ctrl u_sdirq_ctrl (
        .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i), .evt_i(evt_i), .blk_done_i(blk_done_i),
        .mblk_done_i(mblk_done_i), .wp_i(wp_i), .cd_dat3_i(cd_dat3_i),
        .cd_pin_i(cd_pin_i), .cmd_busy_i(cmd_busy_i), .dat_busy_i(dat_busy_i),
        .stat0_o(stat0_o), .stat1_o(stat1_o), .stat2_o(stat2_o),
        .mask0_o(mask0_o), .mask1_o(mask1_o), .ctrl_o(ctrl_o), .irq_o(irq_o)
    );

    // {event byte 1, mask byte 1, expected irq}
    localparam logic [16:0] VEC [8] = '{
        {8'h02, 8'h02, 1'b1},
        {8'h02, 8'hFD, 1'b0},
        {8'h01, 8'hFF, 1'b0},
        {8'h80, 8'h80, 1'b1},
        {8'h14, 8'h10, 1'b1},
        {8'h14, 8'h08, 1'b0},
        {8'hFF, 8'h01, 1'b0},
        {8'h20, 8'h00, 1'b0}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0; wr_data_i = '0;
    endtask

    task automatic pulse1(input logic [7:0] e);
        evt_i = e;
        @(negedge clk);
        evt_i = '0;
    endtask

    initial begin
        cyc(200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        cyc(3);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk("R11 stat0", stat0_o, 8'h00);
        chk("R11 stat1", stat1_o, 8'h00);
        chk("R11 stat2", stat2_o, 8'h00);
        chk("R11 masks", mask0_o | mask1_o, 8'h00);
        chk("R11 ctrl", ctrl_o, 8'h00);
        chk("R11 irq", {7'b0, irq_o}, 8'h00);

        // R7 control byte readback: low nibble reads 0
        wr(3'd5, 8'h8F);
        chk("R7 ctrl readback", ctrl_o, 8'h80);

        // Vector table: R1, R5, R6
        for (int v = 0; v < 8; v++) begin
            wr(3'd1, 8'hFF);
            wr(3'd4, VEC[v][8:1]);
            pulse1(VEC[v][16:9]);
            chk("R1 stat1 flags", stat1_o, VEC[v][16:9]);
            @(negedge clk);
            chk("R5 R6 irq from byte 1", {7'b0, irq_o}, {7'b0, VEC[v][0]});
        end

        // R3 partial clear
        wr(3'd1, 8'hFF);
        pulse1(8'hF0);
        wr(3'd1, 8'h30);
        chk("R3 partial clear", stat1_o, 8'hC0);
        wr(3'd1, 8'hFF);
        chk("R3 full clear", stat1_o, 8'h00);

        // R4 event wins against same-cycle clear
        pulse1(8'h01);
        evt_i = 8'h04;
        wr(3'd1, 8'hFF);
        evt_i = '0;
        chk("R4 set beats clear", stat1_o, 8'h04);

        // R7 global enable off blocks interrupt, then on raises it
        wr(3'd4, 8'h04);
        wr(3'd5, 8'h00);
        @(negedge clk);
        chk("R7 disabled irq", {7'b0, irq_o}, 8'h00);
        wr(3'd5, 8'h80);
        @(negedge clk);
        chk("R7 enabled irq", {7'b0, irq_o}, 8'h01);
        wr(3'd4, 8'h00);
        wr(3'd1, 8'hFF);

        // R2 block / multi-block done, R5 mask byte 0
        blk_done_i = 1'b1; @(negedge clk); blk_done_i = 1'b0;
        mblk_done_i = 1'b1; @(negedge clk); mblk_done_i = 1'b0;
        chk("R2 block flags", stat0_o, 8'h30);
        wr(3'd3, 8'h20);
        @(negedge clk);
        chk("R5 irq from block done", {7'b0, irq_o}, 8'h01);
        wr(3'd0, 8'hFF);
        chk("R3 stat0 clear", stat0_o, 8'h00);

        // R6 low nibble of mask byte 0 ignored, with write-protect live bit set
        wr(3'd3, 8'h0F);
        wp_i = 1'b1;
        cyc(3);
        chk("R2 write protect level", stat0_o, 8'h02);
        chk("R6 mask0 low nibble", {7'b0, irq_o}, 8'h00);
        wp_i = 1'b0;
        cyc(3);
        wr(3'd3, 8'h00);

        // R8 detect pin, active high
        wr(3'd5, 8'hB0);
        wr(3'd0, 8'hFF);
        chk("R8 no event on setup", stat0_o, 8'h00);
        cd_pin_i = 1'b1;
        cyc(2);
        chk("R8 level synced, no flag yet", stat0_o, 8'h08);
        @(negedge clk);
        chk("R8 R9 change and insertion", stat0_o, 8'hC8);
        wr(3'd0, 8'hC0);
        cd_pin_i = 1'b0;
        cyc(3);
        chk("R8 change on removal", stat0_o, 8'h40);

        // R9 active low: selecting makes a card present
        wr(3'd5, 8'hA0);
        @(negedge clk);
        chk("R9 active-low insertion", stat0_o, 8'hC0);
        wr(3'd0, 8'hFF);

        // R8 DAT3 source: pin changes ignored
        wr(3'd5, 8'hC0);
        wr(3'd0, 8'hFF);
        cd_pin_i = 1'b1;
        cyc(3);
        chk("R8 pin ignored with DAT3 source", stat0_o, 8'h08);
        cd_dat3_i = 1'b1;
        cyc(3);
        chk("R8 DAT3 change", stat0_o, 8'h4C);
        wr(3'd3, 8'h40);
        @(negedge clk);
        chk("R5 irq from card change", {7'b0, irq_o}, 8'h01);

        // R10 status byte 2
        cmd_busy_i = 1'b1;
        @(negedge clk);
        chk("R10 command busy", stat2_o, 8'h10);
        wr(3'd2, 8'hFF);
        chk("R10 clock freeze bit", stat2_o, 8'h90);
        cmd_busy_i = 1'b0; dat_busy_i = 1'b1;
        @(negedge clk);
        chk("R10 data busy", stat2_o, 8'hA0);
        dat_busy_i = 1'b0;
        @(negedge clk);
        chk("R10 idle", stat2_o, 8'h80);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule